// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames, one byte per beat, and stores them into buffers that software has posted on a circular ring of 64-bit descriptors in memory. For each buffer it first reads the descriptor at the current ring slot. It then writes the frame bytes into that buffer. Last, it writes the descriptor back with the number of bytes actually stored and a completion code. A frame that does not fit in one buffer continues into the next posted slot. Every filled piece except the last is marked "continues", and the last piece carries the "finished" code.

Software programs the ring base (byte address divided by 8) and the ring length in entries. It announces newly posted buffers by pulsing a doorbell with a count. The block never touches a slot that has not been posted. A frame that finds no buffer is swallowed whole and counted. A frame that runs out of buffers part-way has its last filled piece marked as an error, and the rest of the frame is discarded and counted.

Memory is reached through a single-beat port. Reads return data exactly one cycle after the request, and writes are taken in the same cycle. Buffer bytes go out as single-byte writes with a byte enable. Descriptor words go out as full 8-byte writes.

Top module: `rx_ring_writer`

## Requirements
- R1: A descriptor is fetched by one 64-bit read at byte address (base + slot index) * 8, where base is `cfg_base_i`. No read is issued while frame bytes are being accepted.
- R2: Byte k of a piece is written at byte address buffer_address + k. The write uses `mem_be_o` = 1 << address[2:0], with the byte replicated over all eight lanes of `mem_wdata_o`.
- R3: The completion word is written at the descriptor's own address with all eight byte enables set, and only after every byte of that piece. Its layout is: bits 63:62 zero, bits 61:48 the bytes stored, bit 47 zero, bits 46:40 the completion code, bits 39:0 the unchanged buffer address.
- R4: A frame that ends inside a buffer gets code 0x0F. If `fr_err_i` is high with the last byte, the code is 0x01 instead.
- R5: When a buffer fills and more bytes follow while at least one further buffer is posted, that piece gets code 0x10 and the frame continues in the next slot.
- R6: The slot index advances by one per completion word and wraps to 0 after slot `cfg_size_i` - 1.
- R7: A doorbell pulse with count N adds N posted buffers. Each completion word consumes one. No descriptor is read while the posted count is zero.
- R8: A frame that starts with no posted buffer is accepted and discarded with no memory access, and `drop_cnt_o` rises by one.
- R9: A buffer that fills with more bytes pending and no further posted buffer gets code 0x11. The remaining bytes are discarded and `drop_cnt_o` rises by one.
- R10: While `rst_ni` is low, `fr_ready_o` and `mem_req_o` are 0 and `drop_cnt_o` is 0. The slot index and the posted count restart at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 37 | Ring base, byte address divided by 8 |
| cfg_size_i | input | IDX_W | Ring length in entries (at least 1) |
| db_valid_i | input | 1 | Doorbell pulse |
| db_count_i | input | IDX_W | Buffers posted by this doorbell |
| fr_valid_i | input | 1 | Frame byte valid |
| fr_data_i | input | 8 | Frame byte |
| fr_last_i | input | 1 | Last byte of frame |
| fr_err_i | input | 1 | Frame received in error, sampled with the last byte |
| fr_ready_o | output | 1 | Byte accepted when high together with fr_valid_i |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 40 | Byte address |
| mem_be_o | output | 8 | Byte enables for writes |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, one cycle after a read |
| drop_cnt_o | output | CNT_W | Frames dropped or truncated |

## Verification
The bench posts buffers of 4 and 16 bytes at odd addresses. It sends frames that are shorter than a buffer, exactly one buffer long, and spread over three buffers across the ring wrap, so the finished, continues and error codes each appear in a distinct setting. Frames arriving with no posted buffer, or running out part-way, separate a clean drop from a truncation. A frame flagged in error shows that the error code replaces only the final code. Every memory access is compared against a behavioural model, in order, so a wrong address, lane, length or ordering of completion against data is caught at the cycle it occurs.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  localparam int ADDR_W = 40;
  localparam int LEN_W  = 14;
  localparam int CODE_W = 7;

  localparam logic [CODE_W-1:0] CODE_DONE  = 7'h0F;
  localparam logic [CODE_W-1:0] CODE_MORE  = 7'h10;
  localparam logic [CODE_W-1:0] CODE_RXERR = 7'h01;
  localparam logic [CODE_W-1:0] CODE_TRUNC = 7'h11;

  typedef struct packed {
    logic [1:0]        rsvd;
    logic [LEN_W-1:0]  len;
    logic              stamp;
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] addr;
  } desc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_FETCH, S_DATA, S_DESC, S_DROP
  } st_e;
endpackage

// File: rtl/rdw_ring_state.sv
module rdw_ring_state #(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] cfg_size_i,
  input  logic             db_valid_i,
  input  logic [IDX_W-1:0] db_count_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W:0]   avail_o
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W:0]   avail_q;
  logic [IDX_W:0]   add_w;
  logic [IDX_W:0]   sub_w;

  assign add_w = db_valid_i ? {1'b0, db_count_i} : '0;
  assign sub_w = {{IDX_W{1'b0}}, adv_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      avail_q <= '0;
    end else begin
      if (adv_i) idx_q <= (idx_q >= cfg_size_i - 1'b1) ? '0 : idx_q + 1'b1;
      avail_q <= avail_q + add_w - sub_w;
    end
  end

  assign idx_o   = idx_q;
  assign avail_o = avail_q;

  // never consume a slot that was not posted
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> avail_q != '0);
  p_idx_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_size_i != '0) |-> idx_q < cfg_size_i);
endmodule

// File: rtl/rdw_drop_counter.sv
module rdw_drop_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_drop_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_q == $past(cnt_q) + 1'b1);
  p_drop_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rdw_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-4:0] cfg_base_i,
  input  logic [IDX_W-1:0]  cfg_size_i,
  input  logic              db_valid_i,
  input  logic [IDX_W-1:0]  db_count_i,
  input  logic              fr_valid_i,
  input  logic [7:0]        fr_data_i,
  input  logic              fr_last_i,
  input  logic              fr_err_i,
  output logic              fr_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_be_o,
  output logic [63:0]       mem_wdata_o,
  input  logic [63:0]       mem_rdata_i,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  localparam int BASE_W = ADDR_W - 3;

  st_e               state_q;
  desc_t             cur_q;
  desc_t             done_w;
  logic [LEN_W-1:0]  off_q;
  logic [CODE_W-1:0] code_q;
  logic              cont_q, trunc_q;

  logic [IDX_W-1:0]  idx;
  logic [IDX_W:0]    avail;
  logic              adv, drop_inc, take, fill, spare;
  logic [ADDR_W-1:0] desc_addr, byte_addr;

  rdw_ring_state #(.IDX_W(IDX_W)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_size_i (cfg_size_i),
    .db_valid_i (db_valid_i),
    .db_count_i (db_count_i),
    .adv_i      (adv),
    .idx_o      (idx),
    .avail_o    (avail)
  );

  rdw_drop_counter #(.CNT_W(CNT_W)) u_drop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (drop_inc),
    .cnt_o  (drop_cnt_o)
  );

  assign fr_ready_o = (state_q == S_DATA) || (state_q == S_DROP);
  assign take       = fr_valid_i && fr_ready_o;
  assign fill       = (off_q + 1'b1) == cur_q.len;
  assign spare      = avail > {{IDX_W{1'b0}}, 1'b1};
  assign adv        = (state_q == S_DESC);
  assign drop_inc   = (state_q == S_DROP) && take && fr_last_i;
  assign desc_addr  = {cfg_base_i + BASE_W'(idx), 3'b000};
  assign byte_addr  = cur_q.addr + ADDR_W'(off_q);

  always_comb begin
    done_w       = cur_q;
    done_w.rsvd  = '0;
    done_w.len   = off_q;
    done_w.stamp = 1'b0;
    done_w.code  = code_q;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_READ: mem_req_o = 1'b1;
      S_DATA: if (take) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = byte_addr;
        mem_be_o    = 8'b1 << byte_addr[2:0];
        mem_wdata_o = {8{fr_data_i}};
      end
      S_DESC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 8'hFF;
        mem_wdata_o = done_w;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      off_q   <= '0;
      code_q  <= '0;
      cont_q  <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE:  if (fr_valid_i) state_q <= (avail != '0) ? S_READ : S_DROP;
        S_READ:  state_q <= S_FETCH;
        S_FETCH: begin
          cur_q   <= mem_rdata_i;
          off_q   <= '0;
          state_q <= S_DATA;
        end
        S_DATA: if (take) begin
          off_q <= off_q + 1'b1;
          if (fr_last_i) begin
            code_q  <= fr_err_i ? CODE_RXERR : CODE_DONE;
            cont_q  <= 1'b0;
            trunc_q <= 1'b0;
            state_q <= S_DESC;
          end else if (fill) begin
            // continue only if another posted slot exists
            code_q  <= spare ? CODE_MORE : CODE_TRUNC;
            cont_q  <= spare;
            trunc_q <= !spare;
            state_q <= S_DESC;
          end
        end
        S_DESC:  state_q <= cont_q ? S_READ : (trunc_q ? S_DROP : S_IDLE);
        S_DROP:  if (take && fr_last_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_read_not_in_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_ready_o |-> !(mem_req_o && !mem_we_o));
  p_read_then_fetch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !fr_ready_o && !mem_req_o);
  p_byte_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_be_o != 8'hFF) |-> $onehot(mem_be_o));
  p_desc_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_be_o == 8'hFF) |-> mem_addr_o[2:0] == 3'b000);
  p_desc_after_bytes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_be_o == 8'hFF) |=> !fr_ready_o || state_q == S_DROP);
endmodule

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;
  localparam int IDX_W = 8;
  localparam int CNT_W = 16;
  localparam int RSIZE = 4;
  localparam logic [36:0] BASE = 37'h100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [36:0] cfg_base_i = BASE;
  logic [IDX_W-1:0] cfg_size_i = IDX_W'(RSIZE);
  logic db_valid_i = 1'b0;
  logic [IDX_W-1:0] db_count_i = '0;
  logic fr_valid_i = 1'b0, fr_last_i = 1'b0, fr_err_i = 1'b0;
  logic [7:0] fr_data_i = '0;
  logic fr_ready_o, mem_req_o, mem_we_o;
  logic [39:0] mem_addr_o;
  logic [7:0] mem_be_o;
  logic [63:0] mem_wdata_o;
  logic [63:0] mem_rdata_i = '0;
  logic [CNT_W-1:0] drop_cnt_o;

  always #10 clk_i = ~clk_i;

  rx_ring_writer #(.IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_base_i(cfg_base_i), .cfg_size_i(cfg_size_i),
    .db_valid_i(db_valid_i), .db_count_i(db_count_i), .fr_valid_i(fr_valid_i),
    .fr_data_i(fr_data_i), .fr_last_i(fr_last_i), .fr_err_i(fr_err_i),
    .fr_ready_o(fr_ready_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .drop_cnt_o(drop_cnt_o)
  );

  typedef struct {
    bit          we;
    logic [39:0] addr;
    logic [7:0]  be;
    logic [63:0] data;
    string       tag;
  } acc_t;

  acc_t exp_q[$];
  logic [63:0] dmem [logic [36:0]];
  int m_cap [RSIZE];
  logic [39:0] m_buf [RSIZE];
  int m_idx = 0, m_avail = 0, m_drop = 0;
  int checks = 0, errors = 0;

  // memory: one-cycle read latency
  always @(posedge clk_i)
    if (mem_req_o && !mem_we_o)
      mem_rdata_i <= dmem.exists(mem_addr_o[39:3]) ? dmem[mem_addr_o[39:3]] : 64'h0;

  // per-cycle comparison of every memory access, away from the edges
  always @(negedge clk_i) begin
    #5;
    if (rst_ni && mem_req_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 R7: unexpected access we=%0b addr=%h, expected none", mem_we_o, mem_addr_o);
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        if (mem_we_o !== e.we || mem_addr_o !== e.addr ||
            (e.we && (mem_be_o !== e.be || mem_wdata_o !== e.data))) begin
          errors++;
          $display("FAIL %s: we=%0b addr=%h be=%h data=%h, expected we=%0b addr=%h be=%h data=%h",
                   e.tag, mem_we_o, mem_addr_o, mem_be_o, mem_wdata_o, e.we, e.addr, e.be, e.data);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic post(input int i, input int cap, input logic [39:0] ba);
    m_cap[i] = cap;
    m_buf[i] = ba;
    dmem[BASE + 37'(i)] = {2'b00, 14'(cap), 1'b0, 7'h00, ba};
  endtask

  task automatic ring(input int n);
    @(negedge clk_i);
    db_valid_i = 1'b1;
    db_count_i = IDX_W'(n);
    @(negedge clk_i);
    db_valid_i = 1'b0;
    m_avail += n;
  endtask

  task automatic model_frame(input int n, input bit err, input logic [7:0] seed);
    int pos = 0;
    if (m_avail == 0) begin
      m_drop++;
      return;
    end
    forever begin
      int off = 0;
      logic [6:0] code;
      string tg;
      bit trunc = 0;
      acc_t a;
      a.we = 0; a.addr = {BASE + 37'(m_idx), 3'b000}; a.be = '0; a.data = '0; a.tag = "R1 R6 fetch";
      exp_q.push_back(a);
      while (off < m_cap[m_idx] && pos < n) begin
        logic [39:0] ad;
        logic [7:0] b;
        ad = m_buf[m_idx] + 40'(off);
        b = seed + 8'(pos);
        a.we = 1; a.addr = ad; a.be = 8'b1 << ad[2:0]; a.data = {8{b}}; a.tag = "R2 byte";
        exp_q.push_back(a);
        off++; pos++;
      end
      if (pos == n) begin code = err ? 7'h01 : 7'h0F; tg = "R3 R4 final"; end
      else if (m_avail >= 2) begin code = 7'h10; tg = "R3 R5 more"; end
      else begin code = 7'h11; tg = "R3 R9 trunc"; trunc = 1; end
      a.we = 1; a.addr = {BASE + 37'(m_idx), 3'b000}; a.be = 8'hFF;
      a.data = {2'b00, 14'(off), 1'b0, code, m_buf[m_idx]}; a.tag = tg;
      exp_q.push_back(a);
      m_idx = (m_idx + 1) % RSIZE;
      m_avail--;
      if (pos == n) break;
      if (trunc) begin m_drop++; break; end
    end
  endtask

  task automatic send(input int n, input bit err, input logic [7:0] seed, input string tag);
    model_frame(n, err, seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      fr_valid_i = 1'b1;
      fr_data_i  = seed + 8'(i);
      fr_last_i  = (i == n - 1);
      fr_err_i   = err && (i == n - 1);
      while (!fr_ready_o) @(negedge clk_i);
      @(posedge clk_i);
    end
    @(negedge clk_i);
    fr_valid_i = 1'b0; fr_last_i = 1'b0; fr_err_i = 1'b0;
    repeat (8) @(negedge clk_i);
    check(drop_cnt_o == CNT_W'(m_drop), {tag, " R8 R9 drop count"}, drop_cnt_o, m_drop);
    check(exp_q.size() == 0, {tag, " R3 R7 accesses outstanding"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(fr_ready_o == 0, "R10 ready in reset", fr_ready_o, 0);
    check(mem_req_o == 0, "R10 mem idle in reset", mem_req_o, 0);
    check(drop_cnt_o == 0, "R10 drop count in reset", drop_cnt_o, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < RSIZE; i++) post(i, 4, 40'h2000 + 40'(i * 64 + i));
    send(3, 0, 8'h10, "R8 no buffer");
    ring(3);                                  // R7: only three posted
    send(2, 0, 8'h20, "R4 short good");
    send(3, 1, 8'h30, "R4 error frame");
    send(6, 0, 8'h40, "R9 runs out");
    for (int i = 0; i < RSIZE; i++) post(i, 4, 40'h3000 + 40'(i * 32 + 2 * i + 1));
    ring(4);
    send(10, 0, 8'h50, "R5 R6 span wrap");
    send(4, 0, 8'h60, "R4 exact fit");
    send(2, 0, 8'h70, "R8 empty again");
    post(3, 16, 40'h4005);
    ring(1);
    send(9, 0, 8'h80, "R2 R4 large buffer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule